// File: doc/BRIEF.md
# Transfer Descriptor Completion Unit

This unit decides what happens to a transfer descriptor once the bus transaction it described has finished. The caller presents the descriptor's control word and token word, the result code of the transaction and, for reads from a device, the number of bytes the device returned. One clock later the unit presents the rewritten control word and a three-way verdict: advance the queue, hold the queue, or abort the frame. It also presents interrupt cause flags, process-error and bus-error indications, and a flag telling the caller whether the control word must be written back to memory.

The token is split into packet identifier, device address, endpoint and byte limit, and these fields come out next to the verdict so the caller does not need a second decoder. The retry policy sits entirely here. This covers the two-bit error countdown, NAK handling (a NAK to a SETUP also counts as a timeout), stall, babble on an over-long read, and the short-packet rule that keeps a queue from moving on. Memory access and the transaction itself belong to the caller.

Top module: `td_complete`

## Requirements
- R1: The token splits as PID = bits 7:0, device address = bits 14:8, endpoint = bits 18:15. The byte limit is (bits 31:21 + 1) modulo 2048, so an encoded 0x7FF gives a limit of zero. All four fields appear on the outputs with the verdict.
- R2: Control bit 24 (interrupt on completion) sets cause bit 0, whether or not the descriptor is active. If control bit 23 (active) is clear, the outcome is hold (code 0) and the control word is returned unchanged.
- R3: For an active descriptor, a PID other than IN (0x69), OUT (0xE1) or SETUP (0x2D) gives the fatal outcome (code 2) and raises the process-error output. The control word is returned unchanged.
- R4: Result code OK (0) sets control bits 10:0 to (length - 1) modulo 2048 and clears active. The length is the limit for OUT and SETUP, and the returned count for IN. The outcome is advance (code 1) unless R5 applies.
- R5: For IN with result OK, short-packet detect (control bit 29) set, and length below the limit, cause bit 1 is set and the outcome is hold.
- R6: For IN with result OK and a returned count above the limit, the result becomes babble. A babble result, whether it arises this way or is reported directly (code 4), sets bits 20 and 22, clears active, leaves bits 10:0 unchanged and gives the fatal outcome.
- R7: An active descriptor with isochronous bit 25 set always leaves with active cleared, whatever the result.
- R8: Result timeout (5), no-device (1) or any undefined code (6, 7) sets bit 18 and gives hold. If the error counter in bits 28:27 is nonzero, it is decremented. When the decrement reaches zero, active is cleared and the bus-error output is raised. A counter that is already zero stays zero and leaves active unchanged.
- R9: Result NAK (2) sets bit 19 and gives hold. Active stays set. For a SETUP PID the R8 handling is applied as well.
- R10: Result stall (3) sets bit 22, clears active and gives hold.
- R11: The write-back output is high exactly when the returned control word differs from the control word presented.
- R12: The outputs register the evaluation of the inputs presented with in_valid high, and out_valid follows in_valid by one cycle. While in_valid is low the other outputs hold their values. After reset, out_valid is low and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor and result presented this cycle |
| in_ctrl | input | 32 | Descriptor control/status word as fetched |
| in_token | input | 32 | Descriptor token word |
| in_result | input | 3 | Transaction result code |
| in_count | input | 12 | Bytes returned by the device for IN |
| out_valid | output | 1 | Verdict valid |
| out_ctrl | output | 32 | Rewritten control word |
| out_outcome | output | 2 | 0 hold, 1 advance, 2 fatal |
| out_cause | output | 2 | Bit 0 completion interrupt, bit 1 short packet |
| out_proc_err | output | 1 | Invalid PID seen |
| out_bus_err | output | 1 | Error counter expired |
| out_writeback | output | 1 | Control word changed |
| out_pid | output | 8 | Decoded PID |
| out_dev_addr | output | 7 | Decoded device address |
| out_endp | output | 4 | Decoded endpoint |
| out_limit | output | 11 | Decoded byte limit |

## Verification
The bench targets the following edges.
- Encoded limit 0x7FF. Here a zero-byte transfer must write 0x7FF into the length field, and a design that widens the sum would report a 2048-byte limit.
- An IN count exactly at the limit against one byte over. A wrong comparison either flags babble on a legal packet or lets an over-long read advance.
- The error counter at 1 and at 0. A wrong countdown either wraps to 3 or expires on its own.
- A NAK to a SETUP against a NAK to an IN. Confusing these either retries a setup for ever or burns the error budget on polling.
- An inactive descriptor carrying the completion interrupt bit. The interrupt must still be raised, and the write-back flag must stay low.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

  localparam int WORD_W   = 32;
  localparam int LEN_W    = 11;
  localparam int CNT_W    = 12;
  localparam int RES_W    = 3;

  // control word bit positions (behavioural contract with memory image)
  localparam int B_TMO    = 18;
  localparam int B_NAK    = 19;
  localparam int B_BAB    = 20;
  localparam int B_STL    = 22;
  localparam int B_ACT    = 23;
  localparam int B_IOC    = 24;
  localparam int B_ISO    = 25;
  localparam int B_ERR_LO = 27;
  localparam int B_SPD    = 29;

  localparam logic [7:0] PID_IN    = 8'h69;
  localparam logic [7:0] PID_OUT   = 8'hE1;
  localparam logic [7:0] PID_SETUP = 8'h2D;

  localparam logic [RES_W-1:0] RES_OK      = 3'd0;
  localparam logic [RES_W-1:0] RES_NODEV   = 3'd1;
  localparam logic [RES_W-1:0] RES_NAK     = 3'd2;
  localparam logic [RES_W-1:0] RES_STALL   = 3'd3;
  localparam logic [RES_W-1:0] RES_BABBLE  = 3'd4;
  localparam logic [RES_W-1:0] RES_TIMEOUT = 3'd5;

  typedef enum logic [1:0] {
    OC_HOLD    = 2'd0,
    OC_ADVANCE = 2'd1,
    OC_FATAL   = 2'd2
  } outcome_e;

  typedef struct packed {
    logic [7:0]       pid;
    logic [6:0]       dev_addr;
    logic [3:0]       endp;
    logic [LEN_W-1:0] limit;
  } tok_fields_t;

  typedef struct packed {
    logic [WORD_W-1:0] ctrl;
    outcome_e          outcome;
    logic [1:0]        cause;
    logic              proc_err;
    logic              bus_err;
    logic              writeback;
  } verdict_t;

endpackage

// File: rtl/td_token_split.sv
module td_token_split
  import tdc_pkg::*;
(
  input  logic [WORD_W-1:0] token,
  output tok_fields_t       fields,
  output logic              is_in,
  output logic              is_setup,
  output logic              pid_known
);

  localparam int LIM_LO = WORD_W - LEN_W;

  always_comb begin
    fields.pid      = token[7:0];
    fields.dev_addr = token[14:8];
    fields.endp     = token[18:15];
    fields.limit    = token[WORD_W-1:LIM_LO] + LEN_W'(1);
    is_in           = (token[7:0] == PID_IN);
    is_setup        = (token[7:0] == PID_SETUP);
    pid_known       = is_in || is_setup || (token[7:0] == PID_OUT);
  end

endmodule

// File: rtl/td_len_resolve.sv
module td_len_resolve
  import tdc_pkg::*;
(
  input  logic             is_in,
  input  logic [RES_W-1:0] result,
  input  logic [CNT_W-1:0] count,
  input  logic [LEN_W-1:0] limit,
  output logic [LEN_W-1:0] eff_len,
  output logic [RES_W-1:0] eff_result
);

  logic over;

  always_comb begin
    over       = count > CNT_W'(limit);
    eff_result = result;
    eff_len    = limit;
    if (is_in) begin
      if (result == RES_OK) begin
        if (over) begin
          eff_len    = limit;
          eff_result = RES_BABBLE;
        end else begin
          eff_len    = count[LEN_W-1:0];
        end
      end else begin
        eff_len = '0;
      end
    end
  end

endmodule

// File: rtl/td_rule_eval.sv
module td_rule_eval
  import tdc_pkg::*;
(
  input  logic [WORD_W-1:0] ctrl,
  input  logic              is_in,
  input  logic              is_setup,
  input  logic              pid_known,
  input  logic [LEN_W-1:0]  limit,
  input  logic [LEN_W-1:0]  eff_len,
  input  logic [RES_W-1:0]  eff_result,
  output verdict_t          verdict
);

  logic [WORD_W-1:0] c;
  logic [1:0]        err;
  logic              do_tmo;
  outcome_e          oc;
  logic [1:0]        cause;
  logic              perr;
  logic              berr;

  always_comb begin
    c      = ctrl;
    oc     = OC_HOLD;
    cause  = {1'b0, ctrl[B_IOC]};
    perr   = 1'b0;
    berr   = 1'b0;
    do_tmo = 1'b0;
    err    = ctrl[B_ERR_LO+1:B_ERR_LO];

    if (ctrl[B_ACT]) begin
      if (!pid_known) begin
        oc   = OC_FATAL;
        perr = 1'b1;
      end else begin
        if (ctrl[B_ISO]) c[B_ACT] = 1'b0;
        case (eff_result)
          RES_OK: begin
            c[LEN_W-1:0] = eff_len - LEN_W'(1);
            c[B_ACT]     = 1'b0;
            if (is_in && ctrl[B_SPD] && (eff_len < limit)) begin
              cause[1] = 1'b1;
              oc       = OC_HOLD;
            end else begin
              oc = OC_ADVANCE;
            end
          end
          RES_NAK: begin
            c[B_NAK] = 1'b1;
            do_tmo   = is_setup;
          end
          RES_STALL: begin
            c[B_STL] = 1'b1;
            c[B_ACT] = 1'b0;
          end
          RES_BABBLE: begin
            c[B_BAB] = 1'b1;
            c[B_STL] = 1'b1;
            c[B_ACT] = 1'b0;
            oc       = OC_FATAL;
          end
          default: do_tmo = 1'b1;
        endcase

        if (do_tmo) begin
          c[B_TMO] = 1'b1;
          if (err != 2'd0) begin
            err = err - 2'd1;
            if (err == 2'd0) begin
              c[B_ACT] = 1'b0;
              berr     = 1'b1;
            end
          end
          c[B_ERR_LO+1:B_ERR_LO] = err;
        end
      end
    end

    verdict.ctrl      = c;
    verdict.outcome   = oc;
    verdict.cause     = cause;
    verdict.proc_err  = perr;
    verdict.bus_err   = berr;
    verdict.writeback = (c != ctrl);
  end

endmodule

// File: rtl/td_stage_reg.sv
module td_stage_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         q_valid
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= '0;
      q_valid <= 1'b0;
    end else begin
      q       <= q_nxt;
      q_valid <= en;
    end
  end

endmodule

// File: rtl/td_complete.sv
module td_complete
  import tdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       in_ctrl,
  input  logic [31:0]       in_token,
  input  logic [2:0]        in_result,
  input  logic [11:0]       in_count,
  output logic              out_valid,
  output logic [31:0]       out_ctrl,
  output logic [1:0]        out_outcome,
  output logic [1:0]        out_cause,
  output logic              out_proc_err,
  output logic              out_bus_err,
  output logic              out_writeback,
  output logic [7:0]        out_pid,
  output logic [6:0]        out_dev_addr,
  output logic [3:0]        out_endp,
  output logic [10:0]       out_limit
);

  localparam int STAGE_W = $bits(verdict_t) + $bits(tok_fields_t);

  tok_fields_t      tok;
  logic             is_in, is_setup, pid_known;
  logic [LEN_W-1:0] eff_len;
  logic [RES_W-1:0] eff_result;
  verdict_t         vd;
  verdict_t         vd_q;
  tok_fields_t      tok_q;

  td_token_split u_split (
    .token     (in_token),
    .fields    (tok),
    .is_in     (is_in),
    .is_setup  (is_setup),
    .pid_known (pid_known)
  );

  td_len_resolve u_len (
    .is_in      (is_in),
    .result     (in_result),
    .count      (in_count),
    .limit      (tok.limit),
    .eff_len    (eff_len),
    .eff_result (eff_result)
  );

  td_rule_eval u_rules (
    .ctrl       (in_ctrl),
    .is_in      (is_in),
    .is_setup   (is_setup),
    .pid_known  (pid_known),
    .limit      (tok.limit),
    .eff_len    (eff_len),
    .eff_result (eff_result),
    .verdict    (vd)
  );

  td_stage_reg #(.W(STAGE_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (in_valid),
    .d       ({vd, tok}),
    .q       ({vd_q, tok_q}),
    .q_valid (out_valid)
  );

  assign out_ctrl      = vd_q.ctrl;
  assign out_outcome   = vd_q.outcome;
  assign out_cause     = vd_q.cause;
  assign out_proc_err  = vd_q.proc_err;
  assign out_bus_err   = vd_q.bus_err;
  assign out_writeback = vd_q.writeback;
  assign out_pid       = tok_q.pid;
  assign out_dev_addr  = tok_q.dev_addr;
  assign out_endp      = tok_q.endp;
  assign out_limit     = tok_q.limit;

endmodule

// File: rtl/td_complete_chk.sv
module td_complete_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_ctrl,
  input logic [31:0] in_token,
  input logic        out_valid,
  input logic [31:0] out_ctrl,
  input logic [1:0]  out_outcome,
  input logic [1:0]  out_cause,
  input logic        out_proc_err,
  input logic        out_bus_err,
  input logic        out_writeback,
  input logic [7:0]  out_pid
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid) else $error("valid lost"); // R12

  AST_VALID_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)) else $error("spurious valid"); // R12

  AST_PID_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_pid == $past(in_token[7:0])) else $error("pid"); // R1

  AST_IOC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_cause[0] == $past(in_ctrl[24])) else $error("ioc"); // R2

  AST_PERR_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_proc_err) |-> (out_outcome == 2'd2 && out_ctrl == $past(in_ctrl)))
    else $error("proc err"); // R3

  AST_ADVANCE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_outcome == 2'd1) |-> !out_ctrl[23]) else $error("advance active"); // R4

  AST_ISO_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_ctrl[25]) && $past(in_ctrl[23]) && !out_proc_err) |-> !out_ctrl[23])
    else $error("iso"); // R7

  AST_BUS_ERR_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_bus_err) |-> (out_ctrl[28:27] == 2'd0 && !out_ctrl[23] && out_ctrl[18]))
    else $error("bus err"); // R8

  AST_WRITEBACK_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_writeback == (out_ctrl != $past(in_ctrl))) else $error("wb"); // R11

endmodule

bind td_complete td_complete_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ctrl       (in_ctrl),
  .in_token      (in_token),
  .out_valid     (out_valid),
  .out_ctrl      (out_ctrl),
  .out_outcome   (out_outcome),
  .out_cause     (out_cause),
  .out_proc_err  (out_proc_err),
  .out_bus_err   (out_bus_err),
  .out_writeback (out_writeback),
  .out_pid       (out_pid)
);

// File: tb/sim_td_complete.sv
`timescale 1ns/1ps
module sim_td_complete;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_ctrl;
  logic [31:0] in_token;
  logic [2:0]  in_result;
  logic [11:0] in_count;
  logic        out_valid;
  logic [31:0] out_ctrl;
  logic [1:0]  out_outcome;
  logic [1:0]  out_cause;
  logic        out_proc_err;
  logic        out_bus_err;
  logic        out_writeback;
  logic [7:0]  out_pid;
  logic [6:0]  out_dev_addr;
  logic [3:0]  out_endp;
  logic [10:0] out_limit;

  int n_cmp;
  int n_bad;

  td_complete u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [31:0] ctrl;
    logic [1:0]  outcome;
    logic [1:0]  cause;
    logic        perr;
    logic        berr;
    logic        wb;
    logic [10:0] limit;
  } exp_t;

  function automatic exp_t model(input logic [31:0] c0, input logic [31:0] tk,
                                 input logic [2:0] rs, input logic [11:0] cnt);
    exp_t e;
    logic [7:0]  pid;
    logic [10:0] lim;
    logic [10:0] len;
    logic [2:0]  r;
    logic [1:0]  ec;
    logic        tmo;
    pid = tk[7:0];
    lim = 11'(tk[31:21] + 11'd1);          // R1 limit wraps
    e.ctrl = c0; e.outcome = 2'd0; e.cause = {1'b0, c0[24]};
    e.perr = 1'b0; e.berr = 1'b0; e.limit = lim;
    r = rs; len = lim; tmo = 1'b0;
    if (c0[23]) begin
      if (pid != 8'h69 && pid != 8'hE1 && pid != 8'h2D) begin
        e.outcome = 2'd2; e.perr = 1'b1;
      end else begin
        if (pid == 8'h69) begin
          if (rs == 3'd0 && cnt > {1'b0, lim}) r = 3'd4;
          else len = cnt[10:0];
        end
        if (c0[25]) e.ctrl[23] = 1'b0;
        if (r == 3'd0) begin
          e.ctrl[10:0] = len - 11'd1;
          e.ctrl[23] = 1'b0;
          if (pid == 8'h69 && c0[29] && len < lim) e.cause[1] = 1'b1;
          else e.outcome = 2'd1;
        end else if (r == 3'd2) begin
          e.ctrl[19] = 1'b1;
          tmo = (pid == 8'h2D);
        end else if (r == 3'd3) begin
          e.ctrl[22] = 1'b1; e.ctrl[23] = 1'b0;
        end else if (r == 3'd4) begin
          e.ctrl[20] = 1'b1; e.ctrl[22] = 1'b1; e.ctrl[23] = 1'b0;
          e.outcome = 2'd2;
        end else tmo = 1'b1;
        if (tmo) begin
          e.ctrl[18] = 1'b1;
          ec = c0[28:27];
          if (ec == 2'd1) begin e.ctrl[23] = 1'b0; e.berr = 1'b1; end
          if (ec != 2'd0) ec = ec - 2'd1;
          e.ctrl[28:27] = ec;
        end
      end
    end
    e.wb = (e.ctrl != c0);
    return e;
  endfunction

  task automatic run(input string tag, input logic [31:0] c0, input logic [31:0] tk,
                     input logic [2:0] rs, input logic [11:0] cnt);
    exp_t e;
    e = model(c0, tk, rs, cnt);
    @(negedge clk);
    in_valid = 1'b1; in_ctrl = c0; in_token = tk; in_result = rs; in_count = cnt;
    @(negedge clk);
    in_valid = 1'b0;
    n_cmp++;
    if (!out_valid || out_ctrl !== e.ctrl || out_outcome !== e.outcome ||
        out_cause !== e.cause || out_proc_err !== e.perr || out_bus_err !== e.berr ||
        out_writeback !== e.wb || out_limit !== e.limit || out_pid !== tk[7:0] ||
        out_dev_addr !== tk[14:8] || out_endp !== tk[18:15]) begin
      n_bad++;
      $display("FAIL %s: got v=%b ctrl=%h oc=%0d cause=%b pe=%b be=%b wb=%b lim=%h pid=%h ; exp ctrl=%h oc=%0d cause=%b pe=%b be=%b wb=%b lim=%h pid=%h",
               tag, out_valid, out_ctrl, out_outcome, out_cause, out_proc_err, out_bus_err,
               out_writeback, out_limit, out_pid, e.ctrl, e.outcome, e.cause, e.perr,
               e.berr, e.wb, e.limit, tk[7:0]);
    end
  endtask

  function automatic logic [31:0] tok(input logic [7:0] pid, input logic [10:0] maxm1);
    return {maxm1, 2'b00, 4'h5, 7'h2A, pid};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R12: watchdog expired, got hang expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_ctrl = '0; in_token = '0; in_result = '0; in_count = '0;
    repeat (3) @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b0 || out_ctrl !== 32'h0 || out_outcome !== 2'd0) begin
      n_bad++;
      $display("FAIL R12 reset: got v=%b ctrl=%h oc=%0d exp 0 0 0", out_valid, out_ctrl, out_outcome);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run("R1 field split",          32'h0080_0000, 32'hA5B2_D369, 3'd0, 12'd3);
    run("R2 inactive with ioc",    32'h0100_0000, tok(8'h69, 11'd7), 3'd0, 12'd3);
    run("R2 inactive no change",   32'h1800_0123, tok(8'hE1, 11'd7), 3'd5, 12'd0);
    run("R3 bad pid",              32'h0180_0000, tok(8'h55, 11'd7), 3'd0, 12'd0);
    run("R4 out zero limit",       32'h0080_0000, tok(8'hE1, 11'h7FF), 3'd0, 12'd0);
    run("R4 setup full",           32'h0080_0000, tok(8'h2D, 11'd7), 3'd0, 12'd9);
    run("R4 in zero bytes",        32'h0080_0000, tok(8'h69, 11'd7), 3'd0, 12'd0);
    run("R5 in short spd",         32'h2080_0000, tok(8'h69, 11'd7), 3'd0, 12'd4);
    run("R5 in exact spd",         32'h2080_0000, tok(8'h69, 11'd7), 3'd0, 12'd8);
    run("R6 in one over",          32'h0080_0000, tok(8'h69, 11'd7), 3'd0, 12'd9);
    run("R6 direct babble",        32'h0080_0000, tok(8'hE1, 11'd7), 3'd4, 12'd0);
    run("R7 iso nak",              32'h0280_0000, tok(8'h69, 11'd7), 3'd2, 12'd0);
    run("R8 timeout err3",         32'h1880_0000, tok(8'hE1, 11'd7), 3'd5, 12'd0);
    run("R8 nodev err1",           32'h0880_0000, tok(8'hE1, 11'd7), 3'd1, 12'd0);
    run("R8 timeout err0",         32'h0080_0000, tok(8'hE1, 11'd7), 3'd5, 12'd0);
    run("R8 undefined code",       32'h1080_0000, tok(8'h69, 11'd7), 3'd7, 12'd0);
    run("R9 nak in",               32'h1880_0000, tok(8'h69, 11'd7), 3'd2, 12'd0);
    run("R9 nak setup err1",       32'h0880_0000, tok(8'h2D, 11'd7), 3'd2, 12'd0);
    run("R10 stall",               32'h0080_0000, tok(8'hE1, 11'd7), 3'd3, 12'd0);
    run("R11 no writeback",        32'h0000_0000, tok(8'h69, 11'd7), 3'd0, 12'd1);

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [31:0] c0, tk;
      logic [7:0]  pid;
      int          sel;
      c0 = $urandom;
      if ($urandom_range(0, 3) != 0) c0[23] = 1'b1;
      sel = $urandom_range(0, 3);
      pid = (sel == 0) ? 8'h69 : (sel == 1) ? 8'hE1 : (sel == 2) ? 8'h2D : 8'($urandom);
      tk = $urandom;
      tk[7:0] = pid;
      if ($urandom_range(0, 1) == 0) tk[31:21] = 11'($urandom_range(0, 15));
      run("R4 R8 R11 random", c0, tk, 3'($urandom_range(0, 7)), 12'($urandom_range(0, 20)));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule